// File: doc/BRIEF.md
# PCI Bus Master Tenure Timer

This block limits how long a PCI bus master may go on bursting once it has started a transaction. Software programs a 5-bit count into an 8-bit configuration register. The count is in steps of eight PCI clocks. When the master asserts FRAME#, the block loads a down-counter with the count times eight and lets it run. The counter stops at zero.

While the counter is at zero and the internal grant has been taken away, the block raises a stop-burst request. The master answers it by deasserting FRAME#. If the grant is still held when the counter reaches zero, no stop is requested and the master keeps the bus. If the grant is withdrawn later, the stop follows one clock afterwards. The request stays up until the master reports that the transaction is done, or until a new FRAME# assertion restarts the timer.

Top module: `burst_tenure_timer`

## Requirements
- R1: After reset, the register reads 00h at configuration offset 1Bh and `stopBurst` is low.
- R2: A write to offset 1Bh stores `cfgWrData[7:3]` as the count, and the next read at 1Bh returns it in bits 7:3. A write to any other offset leaves the count unchanged, and a read at any other offset returns 00h.
- R3: Register bits 2:0 are reserved. They always read as 0, and writing 1s to them has no effect.
- R4: Take a count N with the grant low. If `frameStart` is sampled at clock edge k, `stopBurst` is first high after edge k+8N+1.
- R5: If `grantIn` stays high while the counter is at zero, `stopBurst` stays low.
- R6: If `grantIn` falls after the counter has reached zero, `stopBurst` goes high at the first edge that samples `grantIn` low.
- R7: Once high, `stopBurst` stays high until an edge that samples `xferDone` or `frameStart` high. That edge clears it. A `frameStart` also reloads the counter.
- R8: When `xferDone` is sampled in the same cycle in which the stop condition holds, `stopBurst` stays low. Completion wins.
- R9: When a register write and `frameStart` fall in the same cycle, the counter loads the count held before that write. The written count applies from the next transaction.
- R10: A count of 0 means the timer has already expired. With the grant low, `stopBurst` rises at the first edge after the one that samples `frameStart`.
- R11: Between `xferDone` and the next `frameStart`, `stopBurst` stays low whatever `grantIn` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration offset for reads and writes |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Combinational read data for `cfgAddr` |
| grantIn | input | 1 | Internal bus grant to this master |
| frameStart | input | 1 | One-clock strobe: master asserts FRAME# |
| xferDone | input | 1 | One-clock strobe: the transaction has ended |
| stopBurst | output | 1 | Request to deassert FRAME# |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the cycle in which the stop condition becomes true and the cycle in which the transaction is reported done. The bench provokes it with a count of 0 and the grant low, asserting `xferDone` in the cycle right after `frameStart`. `stopBurst` must then stay low.

The second pair is a register write and a FRAME# assertion in the same cycle. The bench judges it by when the stop rises: that time must follow the old count, not the new one.

A behavioural model written with integers predicts `stopBurst` and the read data on every clock.

// File: rtl/btt_pkg.sv
package btt_pkg;

  // strobes from the control side to the timer datapath
  typedef struct packed {
    logic load;     // reload the counter from the register
    logic decr;     // count one clock down (saturating)
    logic setStop;  // stop condition seen this cycle
    logic clrStop;  // transaction ended or restarted
  } tenureCtl_t;

endpackage

// File: rtl/btt_datapath.sv
module btt_datapath
  import btt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 5,
  parameter int STEP_LOG2  = 3,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h1B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  tenureCtl_t        ctl,
  output logic [DATA_W-1:0] cfgRdData,
  output logic              cntZero
);
  localparam int RSV_W   = DATA_W - CNT_W;
  localparam int TIMER_W = CNT_W + STEP_LOG2;

  logic [CNT_W-1:0]   countField;
  logic [TIMER_W-1:0] timerQ;
  logic [DATA_W-1:0]  regImage;
  logic               addrHit;

  assign addrHit = (cfgAddr == CFG_OFFSET);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countField <= '0;
    end else if (cfgWrEn && addrHit) begin
      countField <= cfgWrData[DATA_W-1 -: CNT_W];
    end
  end

  // the load takes the value held before any write in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (ctl.load) begin
      timerQ <= {countField, {STEP_LOG2{1'b0}}};
    end else if (ctl.decr && (timerQ != '0)) begin
      timerQ <= timerQ - TIMER_W'(1);
    end
  end

  generate
    if (RSV_W > 0) begin : g_rsv
      logic unusedRsvBits;
      assign unusedRsvBits = ^cfgWrData[RSV_W-1:0];
      assign regImage = {countField, {RSV_W{1'b0}}};
    end else begin : g_norsv
      assign regImage = countField;
    end
  endgenerate

  assign cfgRdData = addrHit ? regImage : '0;
  assign cntZero   = (timerQ == '0);

endmodule

// File: rtl/btt_control.sv
module btt_control
  import btt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       grantIn,
  input  logic       frameStart,
  input  logic       xferDone,
  input  logic       cntZero,
  output tenureCtl_t ctl,
  output logic       stopBurst
);
  logic activeQ;
  logic stopQ;

  always_comb begin
    ctl.load    = frameStart && !xferDone;
    ctl.decr    = activeQ && !frameStart && !xferDone;
    ctl.clrStop = frameStart || xferDone;
    ctl.setStop = activeQ && cntZero && !grantIn && !ctl.clrStop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
    end else if (xferDone) begin
      activeQ <= 1'b0;
    end else if (frameStart) begin
      activeQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopQ <= 1'b0;
    end else if (ctl.clrStop) begin
      stopQ <= 1'b0;
    end else if (ctl.setStop) begin
      stopQ <= 1'b1;
    end
  end

  assign stopBurst = stopQ;

endmodule

// File: rtl/burst_tenure_timer.sv
module burst_tenure_timer
  import btt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 5,
  parameter int STEP_LOG2  = 3,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h1B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] cfgRdData,
  input  logic              grantIn,
  input  logic              frameStart,
  input  logic              xferDone,
  output logic              stopBurst
);
  tenureCtl_t ctl;
  logic       cntZero;

  btt_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .STEP_LOG2(STEP_LOG2), .CFG_OFFSET(CFG_OFFSET)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .ctl(ctl), .cfgRdData(cfgRdData),
    .cntZero(cntZero)
  );

  btt_control i_control (
    .clk(clk), .rstN(rstN), .grantIn(grantIn), .frameStart(frameStart),
    .xferDone(xferDone), .cntZero(cntZero), .ctl(ctl),
    .stopBurst(stopBurst)
  );

endmodule

// File: rtl/btt_checker.sv
module btt_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h1B
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [DATA_W-1:0] cfgWrData,
  input logic [DATA_W-1:0] cfgRdData,
  input logic              grantIn,
  input logic              frameStart,
  input logic              xferDone,
  input logic              stopBurst
);
  localparam int RSV_W = DATA_W - CNT_W;

  // R3: reserved bits never read back as 1
  always @(negedge clk) begin
    if (rstN) begin
      p_rsv_zero_r3: assert (cfgRdData[RSV_W-1:0] == '0)
        else $error("reserved bits read non-zero");
    end
  end

  // R2: a write at the register offset is visible on the next read there
  p_write_visible_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == CFG_OFFSET) |=>
      (cfgAddr != CFG_OFFSET || cfgRdData[DATA_W-1 -: CNT_W] == $past(cfgWrData[DATA_W-1 -: CNT_W])));

  // R5, R6: a stop only rises after the grant was sampled low
  p_stop_needs_nogrant_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopBurst) |-> $past(!grantIn));

  // R8: completion clears and blocks the stop
  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !stopBurst);

  // R7: a new FRAME# assertion clears the stop
  p_frame_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !stopBurst);

  // R7: the stop holds until done or restart
  p_stop_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stopBurst && !xferDone && !frameStart) |=> stopBurst);

  // R11: no stop can arise while idle after completion
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!stopBurst && $past(xferDone) && !frameStart) |=> !stopBurst);

endmodule

bind burst_tenure_timer btt_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CFG_OFFSET(CFG_OFFSET)
) i_btt_checker (.*);

// File: tb/test_burst_tenure_timer.sv
module test_burst_tenure_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgAddr = 8'h1B;
  logic [7:0] cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic       grantIn = 1'b1;
  logic       frameStart = 1'b0;
  logic       xferDone = 1'b0;
  logic       stopBurst;

  int    nCmp = 0;
  int    nBad = 0;
  bit    finished = 1'b0;
  string curReq = "R1";

  // reference model state
  int       mRemain = 0;
  bit       mActive = 1'b0;
  bit       mStop = 1'b0;
  int       mCount = 0;

  always #10 clk = ~clk;  // 50 MHz

  burst_tenure_timer i_burst_tenure_timer (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .grantIn(grantIn),
    .frameStart(frameStart), .xferDone(xferDone), .stopBurst(stopBurst)
  );

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mRemain = 0; mActive = 1'b0; mStop = 1'b0; mCount = 0;
    end else begin
      if (xferDone) begin
        mActive = 1'b0; mStop = 1'b0;
      end else if (frameStart) begin
        mActive = 1'b1; mStop = 1'b0; mRemain = mCount * 8;
      end else if (mActive) begin
        if (mRemain == 0 && !grantIn) mStop = 1'b1;
        if (mRemain > 0) mRemain = mRemain - 1;
      end
      if (cfgWrEn && cfgAddr == 8'h1B) mCount = int'(cfgWrData[7:3]);
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    logic [7:0] expRd;
    if (!finished) begin
      expRd = (cfgAddr == 8'h1B) ? {mCount[4:0], 3'b000} : 8'h00;
      nCmp++;
      if (stopBurst !== mStop) begin
        nBad++;
        $display("FAIL %s stopBurst actual %0b expected %0b at %0t",
                 curReq, stopBurst, mStop, $time);
      end
      nCmp++;
      if (cfgRdData !== expRd) begin
        nBad++;
        $display("FAIL %s cfgRdData actual %02h expected %02h at %0t",
                 curReq, cfgRdData, expRd, $time);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      cfgWrEn = 1'b0; frameStart = 1'b0; xferDone = 1'b0;
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    tick(1);
    cfgAddr = 8'h1B;
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick(3);

    // R2: store and read back, other offsets ignored
    curReq = "R2";
    writeReg(8'h1B, 8'hA8);
    tick(2);
    writeReg(8'h1C, 8'hFF);
    cfgAddr = 8'h1C; tick(2); cfgAddr = 8'h1B; tick(1);

    // R3: reserved bits
    curReq = "R3";
    writeReg(8'h1B, 8'h17);
    tick(2);

    // R10: count 0, immediate expiry
    curReq = "R10";
    writeReg(8'h1B, 8'h00);
    grantIn = 1'b0; frameStart = 1'b1; tick(1);
    tick(4);
    xferDone = 1'b1; tick(1);

    // R4: count 2, grant low from the start
    curReq = "R4";
    writeReg(8'h1B, 8'h10);
    frameStart = 1'b1; tick(1);
    tick(22);
    xferDone = 1'b1; tick(1);

    // R5: grant held through expiry
    curReq = "R5";
    grantIn = 1'b1;
    writeReg(8'h1B, 8'h08);
    frameStart = 1'b1; tick(1);
    tick(20);

    // R6: grant withdrawn after expiry
    curReq = "R6";
    grantIn = 1'b0; tick(3);

    // R7: sticky, then cleared by restart and by completion
    curReq = "R7";
    grantIn = 1'b1; tick(3);
    frameStart = 1'b1; tick(1);
    grantIn = 1'b0; tick(12);
    xferDone = 1'b1; tick(2);

    // R8: completion in the cycle the stop condition holds
    curReq = "R8";
    writeReg(8'h1B, 8'h00);
    frameStart = 1'b1; tick(1);
    xferDone = 1'b1; tick(1);
    tick(3);

    // R11: idle after completion with grant low
    curReq = "R11";
    grantIn = 1'b0; tick(6);
    grantIn = 1'b1; tick(2);

    // R9: register write in the frameStart cycle
    curReq = "R9";
    writeReg(8'h1B, 8'h18);
    grantIn = 1'b0;
    frameStart = 1'b1; cfgWrEn = 1'b1; cfgWrData = 8'h08; tick(1);
    tick(30);
    xferDone = 1'b1; tick(1);
    frameStart = 1'b1; tick(1);
    tick(12);
    xferDone = 1'b1; tick(2);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nBad++;
      $display("FAIL %s watchdog expired actual running expected finished", curReq);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule